// File: doc/BRIEF.md
# MACsec Transmit Frame Encapsulator

This block sits on the transmit path between the system side and the Ethernet MAC. It takes a plain Ethernet frame as a byte stream with start and end markers and turns it into a secured frame. The two MAC addresses go through unchanged. The block then inserts a security tag built from configuration inputs and routes every payload byte through an external cipher hook. After the last payload byte it appends a 16-byte integrity check value supplied by an external authenticator. The block does not encrypt and does not compute the check value. It only does the framing, the timing of the inserted bytes and the flow control in both directions.

The output stream is longer than the input stream. The input is therefore held off whenever inserted bytes are being sent. There is no buffering at either edge: accepted input bytes and emitted output bytes move on the same handshake. A per-frame bypass choice lets uncontrolled traffic pass through unmodified. Every configuration input is sampled on the first byte of a frame.

Top module: `macsec_tx_framer`

## Requirements
- R1: After reset the block is idle. While `in_valid` is low it drives `out_valid` low, and `in_ready` follows `out_ready`.
- R2: In encapsulation mode, the first 12 input bytes (destination address, then source address) appear unchanged as the first 12 output bytes. `out_sof` is high on output byte 0 only.
- R3: With `sci_incl` low, output bytes 12..19 form an 8-byte tag in this order: 0x88, 0xE5, the TCI/AN byte, `short_len`, then `pkt_num` with the most significant byte first.
- R4: With `sci_incl` high, the tag is 16 bytes. The 8 bytes of R3 are followed by `chan_id`, most significant byte first.
- R5: In the TCI/AN tag byte, bit 5 carries the channel-identifier-present flag and equals `sci_incl`. The other bits come from `tci_an`.
- R6: Every payload input byte is presented on `pt_data` with `pt_valid` high. The output byte in that position is `ct_data`, not the input byte.
- R7: After the last payload byte, the 16 bytes of `icv_value` are emitted with the most significant byte first, and only while `icv_valid` is high. `out_eof` is high only on the final check byte, and `icv_done` pulses on that transfer.
- R8: `in_ready` is low while tag bytes or check bytes are being emitted.
- R9: `in_ready` is never high while `out_ready` is low. A byte offered with `out_valid` high stays on the output, unchanged, until it is taken.
- R10: If `fwd_mode` is high on a frame's first byte, the whole frame is forwarded unmodified. `out_sof` and `out_eof` are copied from the input.
- R11: An input byte that arrives while idle without `in_sof` is consumed and produces no output.
- R12: Configuration inputs are sampled on the accepted first byte. Changes made later in the frame do not alter that frame's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_mode | input | 1 | Bypass the frame without tag or check value |
| sci_incl | input | 1 | Carry the 8-byte channel identifier in the tag |
| tci_an | input | 8 | TCI/AN byte value (bit 5 overridden) |
| short_len | input | 8 | Short-length tag byte |
| pkt_num | input | 32 | Packet number placed in the tag |
| chan_id | input | 64 | Secure channel identifier |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| in_ready | output | 1 | Block accepts the input byte |
| pt_valid | output | 1 | Payload byte presented to the cipher hook |
| pt_data | output | 8 | Payload byte to the cipher hook |
| ct_data | input | 8 | Cipher hook result for `pt_data` |
| icv_valid | input | 1 | Check value is available |
| icv_value | input | 128 | 16-byte check value |
| icv_done | output | 1 | Last check byte transferred |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first byte of a frame |
| out_eof | output | 1 | Output byte is the last byte of a frame |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
Most internal faults show up at the ports within one frame. A wrong position counter or a wrong tag-length choice moves every later byte: the tag, payload and check value all land at the wrong offsets, and `out_eof` falls on the wrong byte. A wrong phase state shows up on the first stalled or inserted byte, either as input accepted while tag or check bytes are going out, or as output that drops or changes under backpressure. Configuration sampled at the wrong time only shows when the inputs change during a frame, so one frame changes them on purpose.

// File: rtl/mst_pkg.sv
package mst_pkg;

    localparam int ADDR_BYTES = 12;
    localparam int TAG_SHORT  = 8;
    localparam int TAG_LONG   = 16;
    localparam int SC_BIT     = 5;
    localparam logic [15:0] SEC_ETYPE = 16'h88E5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TAG,
        ST_PAY,
        ST_ICV,
        ST_BYP
    } phase_e;

    typedef enum logic [1:0] {
        SRC_IN,
        SRC_TAG,
        SRC_CIPH,
        SRC_ICV
    } src_e;

    typedef struct packed {
        logic        sci_en;
        logic [7:0]  tci;
        logic [7:0]  slen;
        logic [31:0] pn;
        logic [63:0] sci;
    } tag_cfg_t;

    function automatic logic [7:0] tag_byte(input tag_cfg_t c, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0: b = SEC_ETYPE[15:8];
            4'd1: b = SEC_ETYPE[7:0];
            4'd2: begin
                b = c.tci;
                b[SC_BIT] = c.sci_en;
            end
            4'd3: b = c.slen;
            4'd4, 4'd5, 4'd6, 4'd7: b = c.pn[8*(7 - int'(idx)) +: 8];
            default: b = c.sci[8*(15 - int'(idx)) +: 8];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mst_tag_reg.sv
module mst_tag_reg
    import mst_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  tag_cfg_t         cfg_in,
    input  logic [CNT_W-1:0] idx,
    output logic [7:0]       tag_data,
    output logic [CNT_W-1:0] tag_last
);
    tag_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_in;
    end

    always_comb begin
        tag_data = tag_byte(cfg_q, 4'(idx));
        tag_last = cfg_q.sci_en ? CNT_W'(TAG_LONG - 1) : CNT_W'(TAG_SHORT - 1);
    end
endmodule

// File: rtl/mst_icv_mux.sv
module mst_icv_mux #(
    parameter int ICV_BYTES = 16,
    parameter int CNT_W     = 4
) (
    input  logic [8*ICV_BYTES-1:0] icv,
    input  logic [CNT_W-1:0]       idx,
    output logic [7:0]             icv_byte
);
    logic [7:0] lane [ICV_BYTES];

    for (genvar g = 0; g < ICV_BYTES; g++) begin : g_lane
        assign lane[g] = icv[8*(ICV_BYTES-1-g) +: 8];
    end

    always_comb begin
        icv_byte = 8'h00;
        for (int k = 0; k < ICV_BYTES; k++)
            if (idx == CNT_W'(k)) icv_byte = lane[k];
    end
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
    import mst_pkg::*;
#(
    parameter int ICV_BYTES = 16,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             out_ready,
    input  logic             icv_valid,
    input  logic             bypass,
    input  logic [CNT_W-1:0] tag_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic             load_cfg,
    output logic             icv_done,
    output logic             pt_valid,
    output src_e             src,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] ICV_LAST  = CNT_W'(ICV_BYTES - 1);

    phase_e st;
    logic   in_fire, out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        pt_valid  = 1'b0;
        icv_done  = 1'b0;
        src       = SRC_IN;
        case (st)
            ST_IDLE: begin
                in_ready  = out_ready;
                out_valid = in_valid && in_sof;
                out_sof   = 1'b1;
                out_eof   = in_eof && bypass;
            end
            ST_ADDR: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_TAG: begin
                out_valid = 1'b1;
                src       = SRC_TAG;
            end
            ST_PAY: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                pt_valid  = in_valid;
                src       = SRC_CIPH;
            end
            ST_ICV: begin
                out_valid = icv_valid;
                out_eof   = (cnt == ICV_LAST);
                icv_done  = icv_valid && out_ready && (cnt == ICV_LAST);
                src       = SRC_ICV;
            end
            ST_BYP: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_eof   = in_eof;
            end
            default: ;
        endcase
    end

    assign load_cfg = (st == ST_IDLE) && in_fire && in_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE:
                    if (in_fire && in_sof) begin
                        if (bypass) begin
                            st <= in_eof ? ST_IDLE : ST_BYP;
                        end else begin
                            st  <= ST_ADDR;
                            cnt <= CNT_W'(1);
                        end
                    end
                ST_ADDR:
                    if (in_fire) begin
                        if (cnt == ADDR_LAST) begin
                            st  <= ST_TAG;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                ST_TAG:
                    if (out_fire) begin
                        if (cnt == tag_last) begin
                            st  <= ST_PAY;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                ST_PAY:
                    if (in_fire && in_eof) begin
                        st  <= ST_ICV;
                        cnt <= '0;
                    end
                ST_ICV:
                    if (out_fire) begin
                        if (cnt == ICV_LAST) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                ST_BYP:
                    if (in_fire && in_eof) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/macsec_tx_framer.sv
module macsec_tx_framer
    import mst_pkg::*;
#(
    parameter int ICV_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fwd_mode,
    input  logic                   sci_incl,
    input  logic [7:0]             tci_an,
    input  logic [7:0]             short_len,
    input  logic [31:0]            pkt_num,
    input  logic [63:0]            chan_id,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    input  logic                   in_sof,
    input  logic                   in_eof,
    output logic                   in_ready,
    output logic                   pt_valid,
    output logic [7:0]             pt_data,
    input  logic [7:0]             ct_data,
    input  logic                   icv_valid,
    input  logic [8*ICV_BYTES-1:0] icv_value,
    output logic                   icv_done,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic                   out_sof,
    output logic                   out_eof,
    input  logic                   out_ready
);
    localparam int MAX_CNT = (ICV_BYTES > TAG_LONG) ? ICV_BYTES : TAG_LONG;
    localparam int CNT_W   = $clog2(MAX_CNT);

    tag_cfg_t         cfg_in;
    logic             load_cfg;
    logic [CNT_W-1:0] cnt, tag_last;
    logic [7:0]       tag_data, icv_byte;
    src_e             src;

    assign cfg_in = '{sci_en: sci_incl, tci: tci_an, slen: short_len,
                      pn: pkt_num, sci: chan_id};
    assign pt_data = in_data;

    mst_ctrl #(.ICV_BYTES(ICV_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .out_ready(out_ready), .icv_valid(icv_valid), .bypass(fwd_mode),
        .tag_last(tag_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .load_cfg(load_cfg), .icv_done(icv_done),
        .pt_valid(pt_valid), .src(src), .cnt(cnt)
    );

    mst_tag_reg #(.CNT_W(CNT_W)) u_tag (
        .clk(clk), .rst(rst), .load(load_cfg), .cfg_in(cfg_in),
        .idx(cnt), .tag_data(tag_data), .tag_last(tag_last)
    );

    mst_icv_mux #(.ICV_BYTES(ICV_BYTES), .CNT_W(CNT_W)) u_icv (
        .icv(icv_value), .idx(cnt), .icv_byte(icv_byte)
    );

    always_comb begin
        case (src)
            SRC_TAG:  out_data = tag_data;
            SRC_CIPH: out_data = ct_data;
            SRC_ICV:  out_data = icv_byte;
            default:  out_data = in_data;
        endcase
    end
endmodule

// File: rtl/mst_sva.sv
module mst_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_eof,
    input logic       icv_done,
    input logic       pt_valid
);
    assert_ready_needs_sink_R9: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_ready);

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_last_icv_is_eof_R7: assert property (@(posedge clk) disable iff (rst)
        icv_done |-> (out_valid && out_ready && out_eof));

    assert_no_input_during_icv_R8: assert property (@(posedge clk) disable iff (rst)
        icv_done |-> !in_ready);

    assert_hook_feeds_output_R6: assert property (@(posedge clk) disable iff (rst)
        pt_valid |-> out_valid);
endmodule

bind macsec_tx_framer mst_sva u_mst_sva (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof),
    .icv_done(icv_done), .pt_valid(pt_valid)
);

// File: tb/macsec_tx_framer_tb.sv
module macsec_tx_framer_tb;
    logic clk = 0, rst = 1;
    logic fwd_mode = 0, sci_incl = 0;
    logic [7:0] tci_an = 0, short_len = 0;
    logic [31:0] pkt_num = 0;
    logic [63:0] chan_id = 0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_ready;
    logic [7:0] in_data = 0;
    logic pt_valid, icv_done, icv_valid = 0;
    logic [7:0] pt_data, ct_data;
    logic [127:0] icv_value = 0;
    logic out_valid, out_sof, out_eof, out_ready = 1;
    logic [7:0] out_data;

    int n_chk = 0, n_bad = 0;
    bit stall_en = 0;
    int done_cnt = 0;
    logic [7:0] got_q[$];
    bit sof_q[$], eof_q[$];

    always #5 clk = ~clk;

    assign ct_data = pt_data ^ 8'hA5;

    macsec_tx_framer u_dut (.*);

    always begin
        @(posedge clk); #1;
        out_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            got_q.push_back(out_data);
            sof_q.push_back(out_sof);
            eof_q.push_back(out_eof);
        end
        if (!rst && icv_done) done_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic send(input logic [7:0] b, input logic s, input logic e);
        in_valid = 1; in_data = b; in_sof = s; in_eof = e;
        do @(negedge clk); while (!in_ready);
        tick();
        in_valid = 0; in_sof = 0; in_eof = 0;
    endtask

    function automatic logic [7:0] exp_tag(input int i, input logic sc, input logic [7:0] t,
                                           input logic [7:0] sl, input logic [31:0] pn,
                                           input logic [63:0] sci);
        case (i)
            0: return 8'h88;
            1: return 8'hE5;
            2: return {t[7:6], sc, t[4:0]};
            3: return sl;
            4, 5, 6, 7: return pn[8*(7-i) +: 8];
            default: return sci[8*(15-i) +: 8];
        endcase
    endfunction

    logic [7:0] fr[$];
    logic [7:0] exq[$];

    task automatic run_frame(input bit byp, input int plen, input bit gaps,
                             input bit cfg_change, input bit icv_late, input string req);
        logic sc; logic [7:0] t, sl; logic [31:0] pn; logic [63:0] sci; logic [127:0] icv;
        int wait_n;
        fr.delete(); exq.delete(); got_q.delete(); sof_q.delete(); eof_q.delete();
        done_cnt = 0;
        sc = 1'($urandom); t = 8'($urandom); sl = 8'($urandom); pn = $urandom;
        sci = {$urandom, $urandom}; icv = {$urandom, $urandom, $urandom, $urandom};
        fwd_mode = byp; sci_incl = sc; tci_an = t; short_len = sl; pkt_num = pn; chan_id = sci;
        icv_value = icv; icv_valid = !icv_late;
        for (int i = 0; i < 12 + plen; i++) fr.push_back(8'($urandom));
        for (int i = 0; i < 12; i++) exq.push_back(fr[i]);
        if (byp) begin
            for (int i = 12; i < 12 + plen; i++) exq.push_back(fr[i]);
        end else begin
            for (int i = 0; i < (sc ? 16 : 8); i++) exq.push_back(exp_tag(i, sc, t, sl, pn, sci));
            for (int i = 12; i < 12 + plen; i++) exq.push_back(fr[i] ^ 8'hA5);
            for (int i = 0; i < 16; i++) exq.push_back(icv[8*(15-i) +: 8]);
        end
        for (int i = 0; i < fr.size(); i++) begin
            send(fr[i], i == 0, i == fr.size() - 1);
            if (cfg_change && i == 2) begin
                sci_incl = !sc; tci_an = ~t; short_len = ~sl; pkt_num = ~pn; chan_id = ~sci;
            end
            if (gaps && ($urandom % 3 == 0)) repeat ($urandom % 3) tick();
        end
        if (icv_late) begin
            repeat (6) tick();
            @(negedge clk);
            chk(got_q.size() == exq.size() - 16, "R7", "bytes out while check value absent",
                got_q.size(), exq.size() - 16);
            tick();
            icv_valid = 1;
        end
        wait_n = 0;
        while (got_q.size() < exq.size() && wait_n < 400) begin tick(); wait_n++; end
        repeat (3) tick();
        chk(got_q.size() == exq.size(), req, "frame length", got_q.size(), exq.size());
        for (int i = 0; i < exq.size() && i < got_q.size(); i++) begin
            string r;
            if (byp) r = "R10";
            else if (i < 12) r = "R2";
            else if (i < 12 + (sc ? 16 : 8)) r = cfg_change ? "R12" : (sc ? "R4" : "R3");
            else if (i < exq.size() - 16) r = "R6";
            else r = "R7";
            if (!byp && i == 14) r = "R5";
            chk(got_q[i] == exq[i], r, $sformatf("byte %0d", i), got_q[i], exq[i]);
            chk(sof_q[i] == (i == 0), byp ? "R10" : "R2", $sformatf("sof at %0d", i), sof_q[i], i == 0);
            chk(eof_q[i] == (i == exq.size() - 1), byp ? "R10" : "R7", $sformatf("eof at %0d", i),
                eof_q[i], i == exq.size() - 1);
        end
        if (!byp) chk(done_cnt == 1, "R7", "icv_done pulses", done_cnt, 1);
        fwd_mode = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) tick();
        rst = 0;
        tick();
        @(negedge clk);
        chk(out_valid == 0, "R1", "out_valid idle", out_valid, 0);
        chk(in_ready == out_ready, "R1", "in_ready follows out_ready", in_ready, out_ready);
        tick();

        // R8: while tag bytes go out the input must be held off
        in_valid = 1; in_sof = 1; in_data = 8'h11; fwd_mode = 0;
        do @(negedge clk); while (!in_ready);
        tick(); in_sof = 0;
        for (int i = 1; i < 12; i++) begin
            in_data = 8'(i);
            do @(negedge clk); while (!in_ready);
            tick();
        end
        in_data = 8'h77; in_eof = 1;
        @(negedge clk);
        chk(in_ready == 0, "R8", "in_ready during tag", in_ready, 0);
        do @(negedge clk); while (!in_ready);
        tick(); in_valid = 0; in_eof = 0;
        icv_valid = 1;
        @(negedge clk);
        chk(in_ready == 0, "R8", "in_ready during check value", in_ready, 0);
        repeat (20) tick();
        got_q.delete(); sof_q.delete(); eof_q.delete();

        // R11: stray byte while idle
        send(8'h3C, 0, 0);
        repeat (3) tick();
        chk(got_q.size() == 0, "R11", "stray byte output count", got_q.size(), 0);

        run_frame(0, 1, 0, 0, 0, "R3");
        run_frame(0, 40, 0, 0, 0, "R4");
        run_frame(0, 5, 0, 1, 0, "R12");
        run_frame(0, 9, 0, 0, 1, "R7");
        run_frame(1, 20, 0, 0, 0, "R10");
        run_frame(1, 0, 1, 0, 0, "R10");
        stall_en = 1;
        for (int k = 0; k < 30; k++)
            run_frame(($urandom % 5) == 0, 1 + ($urandom % 50), 1, 0, 0, "R9");
        stall_en = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule